// File: doc/BRIEF.md
# Four-Bank 2x Image Upscaler

This block doubles an image in both dimensions. For every input pixel it takes one 2x2 group of output values on a single valid-qualified input. Upstream logic normally fills the group as three zeros followed by the pixel. The four values go to four private storage banks, one value per bank, at an address given by the pixel's raster index. Each bank therefore holds every output position of one row/column parity.

A start pulse captures the input image width and height and begins the fill phase. The last group of the image ends the fill phase. The block then drains the banks in raster order of the enlarged image and writes one value per cycle to a sequential output memory port. To do this it alternates between the two even-row banks for even output rows and between the two odd-row banks for odd output rows. When the final value has been written, a one-cycle done pulse closes the operation and the block returns to idle.

Top module: `quad_bank_upscaler`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `wr_en_o` are low.
- R2: A `start` pulse taken while idle captures `in_cols` and `in_rows` and raises `busy` in the next cycle.
- R3: Group element k (bits k*DATA_W upward) belongs to output row parity k/2 and output column parity k%2. Element 0 is even row and even column, element 1 is even row and odd column, element 2 is odd row and even column, and element 3 is odd row and odd column.
- R4: The value written at output address a equals element (R%2)*2+(C%2) of input pixel (R/2)*in_cols + C/2, where R = a / (2*in_cols) and C = a % (2*in_cols).
- R5: The drain writes addresses 0 to 4*in_cols*in_rows-1 in increasing order, one per cycle with no gaps.
- R6: `wr_en_o` stays low during the fill phase. The first write appears in the second cycle after the clock edge that accepts the last group.
- R7: `done` is high for exactly one cycle, the cycle after the final write, with `busy` still high. `busy` is low in the cycle after that.
- R8: A `grp_valid` group presented while the block is idle or draining has no effect on the written image, and the block accepts no group while `grp_valid` is low.
- R9: A `start` pulse while `busy` is high is ignored. The image size of the operation in progress is kept.
- R10: Every size from 1x1 up to MAX_COLS x MAX_ROWS is handled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation, taken only while idle |
| in_cols | input | COL_W | Input image width in pixels, 1..MAX_COLS |
| in_rows | input | ROW_W | Input image height in pixels, 1..MAX_ROWS |
| grp_valid | input | 1 | A 2x2 group is present on grp_data |
| grp_data | input | 4*DATA_W | Four output values for one input pixel, element k at bits k*DATA_W |
| wr_en_o | output | 1 | Output memory write strobe |
| wr_addr_o | output | OA_W | Output memory address |
| wr_data_o | output | DATA_W | Output memory write data |
| busy | output | 1 | Operation in progress, from after start through done |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
A fault in the fill pointer, the bank striping or the drain row base produces a wrong value at a known output address. The failure shows within the first drained row that reads the affected pixel, so at most 2*in_cols cycles after the fault takes effect. A fault in the phase control shows sooner. It appears as a write strobe during filling, a gap or repeat in the address sequence, or a done pulse at the wrong distance from the last write. Sweeping every image size up to 8x8 places each of these faults at several row and column boundaries.

// File: rtl/upx_pkg.sv
package upx_pkg;

   localparam int unsigned NUM_BANKS = 4;

   typedef enum logic [2:0] {
      UPX_IDLE,
      UPX_FILL,
      UPX_DRAIN,
      UPX_FLUSH,
      UPX_FINISH
   } upx_state_e;

endpackage

// File: rtl/upx_bank.sv
module upx_bank #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("upx_bank: DEPTH must be at least 1");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];

   // R3
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (32'(wr_addr) < DEPTH));

endmodule

// File: rtl/upx_drain_seq.sv
module upx_drain_seq #(
   parameter int unsigned MAX_COLS = 8,
   parameter int unsigned MAX_ROWS = 8,
   localparam int unsigned COL_W   = $clog2(MAX_COLS + 1),
   localparam int unsigned ROW_W   = $clog2(MAX_ROWS + 1),
   localparam int unsigned DEPTH   = MAX_COLS * MAX_ROWS,
   localparam int unsigned BA_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned OA_W    = $clog2(4 * DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [COL_W-1:0] cols,
   input  logic [ROW_W-1:0] rows,
   output logic [1:0]       bank_sel,
   output logic [BA_W-1:0]  bank_addr,
   output logic [OA_W-1:0]  out_idx,
   output logic             last
);

   logic [COL_W:0]  ocol;
   logic [ROW_W:0]  orow;
   logic [BA_W-1:0] row_base;
   logic            col_end;
   logic            row_end;

   assign col_end   = (ocol == ({cols, 1'b0} - (COL_W+1)'(1)));
   assign row_end   = (orow == ({rows, 1'b0} - (ROW_W+1)'(1)));
   assign last      = col_end && row_end;
   assign bank_sel  = {orow[0], ocol[0]};
   assign bank_addr = row_base + BA_W'(ocol[COL_W:1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ocol     <= '0;
         orow     <= '0;
         row_base <= '0;
         out_idx  <= '0;
      end else if (clear) begin
         ocol     <= '0;
         orow     <= '0;
         row_base <= '0;
         out_idx  <= '0;
      end else if (step) begin
         out_idx <= out_idx + OA_W'(1);
         if (col_end) begin
            ocol <= '0;
            orow <= orow + (ROW_W+1)'(1);
            if (orow[0]) row_base <= row_base + BA_W'(cols);
         end else begin
            ocol <= ocol + (COL_W+1)'(1);
         end
      end
   end

   // R5
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear) |=> (out_idx == $past(out_idx) + OA_W'(1)));

   // R4
   base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (32'(bank_addr) < DEPTH));

endmodule

// File: rtl/quad_bank_upscaler.sv
module quad_bank_upscaler
   import upx_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned MAX_COLS = 8,
   parameter int unsigned MAX_ROWS = 8,
   localparam int unsigned COL_W   = $clog2(MAX_COLS + 1),
   localparam int unsigned ROW_W   = $clog2(MAX_ROWS + 1),
   localparam int unsigned DEPTH   = MAX_COLS * MAX_ROWS,
   localparam int unsigned BA_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned OA_W    = $clog2(4 * DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [COL_W-1:0]              in_cols,
   input  logic [ROW_W-1:0]              in_rows,
   input  logic                          grp_valid,
   input  logic [NUM_BANKS*DATA_W-1:0]   grp_data,
   output logic                          wr_en_o,
   output logic [OA_W-1:0]               wr_addr_o,
   output logic [DATA_W-1:0]             wr_data_o,
   output logic                          busy,
   output logic                          done
);

   if (DATA_W < 1 || MAX_COLS < 1 || MAX_ROWS < 1) begin : g_bad_cfg
      $error("quad_bank_upscaler: widths and maxima must be at least 1");
   end

   upx_state_e        state;
   logic [COL_W-1:0]  cols_q;
   logic [ROW_W-1:0]  rows_q;
   logic [BA_W:0]     total_q;
   logic [BA_W-1:0]   wr_ptr;
   logic              accept;
   logic              fill_last;
   logic              seq_last;
   logic [1:0]        bank_sel;
   logic [BA_W-1:0]   bank_addr;
   logic [OA_W-1:0]   out_idx;
   logic [DATA_W-1:0] bank_rd [NUM_BANKS];

   assign accept    = (state == UPX_FILL) && grp_valid;
   assign fill_last = ({1'b0, wr_ptr} == (total_q - (BA_W+1)'(1)));
   assign busy      = (state != UPX_IDLE);
   assign done      = (state == UPX_FINISH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= UPX_IDLE;
         cols_q  <= COL_W'(1);
         rows_q  <= ROW_W'(1);
         total_q <= (BA_W+1)'(1);
         wr_ptr  <= '0;
      end else begin
         unique case (state)
            UPX_IDLE: begin
               if (start) begin
                  cols_q  <= in_cols;
                  rows_q  <= in_rows;
                  total_q <= (BA_W+1)'(in_cols) * (BA_W+1)'(in_rows);
                  wr_ptr  <= '0;
                  state   <= UPX_FILL;
               end
            end
            UPX_FILL: begin
               if (accept) begin
                  wr_ptr <= wr_ptr + BA_W'(1);
                  if (fill_last) state <= UPX_DRAIN;
               end
            end
            UPX_DRAIN: begin
               if (seq_last) state <= UPX_FLUSH;
            end
            UPX_FLUSH:  state <= UPX_FINISH;
            UPX_FINISH: state <= UPX_IDLE;
            default:    state <= UPX_IDLE;
         endcase
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      upx_bank #(
         .DATA_W (DATA_W),
         .DEPTH  (DEPTH)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (accept),
         .wr_addr (wr_ptr),
         .wr_data (grp_data[b*DATA_W +: DATA_W]),
         .rd_addr (bank_addr),
         .rd_data (bank_rd[b])
      );
   end

   upx_drain_seq #(
      .MAX_COLS (MAX_COLS),
      .MAX_ROWS (MAX_ROWS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state == UPX_IDLE),
      .step      (state == UPX_DRAIN),
      .cols      (cols_q),
      .rows      (rows_q),
      .bank_sel  (bank_sel),
      .bank_addr (bank_addr),
      .out_idx   (out_idx),
      .last      (seq_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o   <= (state == UPX_DRAIN);
         wr_addr_o <= out_idx;
         wr_data_o <= bank_rd[bank_sel];
      end
   end

   // R2
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + OA_W'(1)));

   // R6
   no_write_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == UPX_FILL) |-> !wr_en_o);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R7
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(wr_en_o));

   // R8
   no_fill_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == UPX_DRAIN) |=> $stable(wr_ptr));

   // R9
   dims_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> ($stable(cols_q) && $stable(rows_q)));

   // R10
   dims_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |-> (in_cols != '0 && 32'(in_cols) <= MAX_COLS &&
                            in_rows != '0 && 32'(in_rows) <= MAX_ROWS));

endmodule

// File: tb/sim_quad_bank_upscaler.sv
`timescale 1ns/1ps
module sim_quad_bank_upscaler;

   localparam int DW = 8;
   localparam int MC = 8;
   localparam int MR = 8;
   localparam int CW = $clog2(MC + 1);
   localparam int RW = $clog2(MR + 1);
   localparam int AW = $clog2(4 * MC * MR);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [CW-1:0] in_cols;
   logic [RW-1:0] in_rows;
   logic          grp_valid;
   logic [4*DW-1:0] grp_data;
   logic          wr_en_o;
   logic [AW-1:0] wr_addr_o;
   logic [DW-1:0] wr_data_o;
   logic          busy;
   logic          done;

   int vectors = 0;
   int fails   = 0;
   bit ended   = 1'b0;

   always #4 clk = ~clk;

   quad_bank_upscaler #(
      .DATA_W   (DW),
      .MAX_COLS (MC),
      .MAX_ROWS (MR)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .in_cols   (in_cols),
      .in_rows   (in_rows),
      .grp_valid (grp_valid),
      .grp_data  (grp_data),
      .wr_en_o   (wr_en_o),
      .wr_addr_o (wr_addr_o),
      .wr_data_o (wr_data_o),
      .busy      (busy),
      .done      (done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] elem(input int p, input int k, input int c, input int r);
      return DW'((p * 4 + k) ^ (c * 16 + r));
   endfunction

   function automatic logic [4*DW-1:0] group(input int p, input int c, input int r);
      logic [4*DW-1:0] g;
      for (int k = 0; k < 4; k++) g[k*DW +: DW] = elem(p, k, c, r);
      return g;
   endfunction

   task automatic run_cfg(input int c, input int r);
      int n = c * r;
      // R8: a group offered while idle must leave the block untouched
      @(negedge clk);
      grp_valid = 1'b1;
      grp_data  = '1;
      @(negedge clk);
      chk(!busy && !wr_en_o, "R8 idle group ignored", int'(busy), 0);
      grp_valid = 1'b0;
      start     = 1'b1;
      in_cols   = CW'(c);
      in_rows   = RW'(r);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      for (int p = 0; p < n; p++) begin
         if (p % 3 == 2) begin
            grp_valid = 1'b0;
            grp_data  = ~group(p, c, r);
            start     = 1'b0;
            @(negedge clk);
            chk(!wr_en_o, "R8 R6 gap cycle", int'(wr_en_o), 0);
         end
         grp_valid = 1'b1;
         grp_data  = group(p, c, r);
         if (p == 1) begin
            // R9: restart with another size while filling
            start   = 1'b1;
            in_cols = CW'(1);
            in_rows = RW'(1);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         chk(!wr_en_o, "R6 no write while filling", int'(wr_en_o), 0);
      end
      // R8 R9: junk groups and start pulses throughout the drain
      grp_valid = 1'b1;
      grp_data  = '0;
      start     = 1'b1;
      in_cols   = CW'(1);
      in_rows   = RW'(1);
      for (int idx = 0; idx < 4 * n; idx++) begin
         int rr = idx / (2 * c);
         int cc = idx % (2 * c);
         int p  = (rr / 2) * c + cc / 2;
         int k  = (rr % 2) * 2 + (cc % 2);
         @(negedge clk);
         chk(wr_en_o == 1'b1, "R5 R6 write strobe", int'(wr_en_o), 1);
         chk(int'(wr_addr_o) == idx, "R5 address order", int'(wr_addr_o), idx);
         chk(wr_data_o == elem(p, k, c, r), "R3 R4 R10 output value",
             int'(wr_data_o), int'(elem(p, k, c, r)));
      end
      @(negedge clk);
      start     = 1'b0;
      grp_valid = 1'b0;
      chk(done == 1'b1, "R7 done after last write", int'(done), 1);
      chk(wr_en_o == 1'b0, "R7 R9 no extra write", int'(wr_en_o), 0);
      chk(busy == 1'b1, "R7 busy during done", int'(busy), 1);
      @(negedge clk);
      chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
      chk(busy == 1'b0, "R7 busy falls", int'(busy), 0);
   endtask

   initial begin
      rst_n     = 1'b0;
      start     = 1'b0;
      in_cols   = '0;
      in_rows   = '0;
      grp_valid = 1'b0;
      grp_data  = '0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !wr_en_o, "R1 state in reset",
          int'({busy, done, wr_en_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !wr_en_o, "R1 state after reset",
          int'({busy, done, wr_en_o}), 0);
      // R10: every size up to the maxima
      for (int c = 1; c <= MC; c++) begin
         for (int r = 1; r <= MR; r++) begin
            run_cfg(c, r);
         end
      end
      if (!ended) begin
         ended = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         vectors++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule